// File: doc/BRIEF.md
# Three-Level T-Leg Gate Sequencer

This block drives the four gate enables of one leg of a single-phase three-level T-type inverter. The leg has an outer high switch that connects the output to +VDC/2, and an outer low switch that connects it to −VDC/2. Between them sits a bidirectional middle path that clamps the output to the neutral point. That path is built from a plus-side middle switch and a minus-side middle switch. A signed reference sample is compared against a symmetric triangular carrier to choose the level in each clock cycle.

The choice then goes through a half-wave-dependent pattern. While the sampled reference is non-negative, the minus-side middle switch stays on and only the high switch and the plus-side middle switch trade places. While the reference is negative, the plus-side middle switch stays on and the low switch trades places with the minus-side middle switch. Every gate turns on only after its request has been present for a programmable number of clock cycles, and turns off at once. This gives a blanking interval at each commutation and drops on-pulses that are too short.

The carrier half-period and the dead time are given in clock cycles. With a 100 MHz clock, half-periods of 3125 and 312 give carriers of 16 kHz and 160 kHz, and dead counts of 10 and 40 give 100 ns and 400 ns. The block has no fault handling and no current loop. It expects the reference and the settings from the surrounding controller.

Top module: `tlgs_gate_seq`

## Requirements
- R1: The block maps each level onto the gates. Positive level drives `gate_hi_o`. Zero level leaves both middle gates (`gate_mp_o`, `gate_mn_o`) on and both outer gates off. Negative level drives `gate_lo_o`. A zero reference gives the zero level all the time. The most negative reference value gives the full negative level.
- R2: While the sampled reference is non-negative (sign bit 0), `gate_mn_o` stays on continuously and `gate_lo_o` stays off. Only `gate_hi_o` and `gate_mp_o` commutate.
- R3: While the sampled reference is negative (sign bit 1), `gate_mp_o` stays on continuously and `gate_hi_o` stays off. Only `gate_lo_o` and `gate_mn_o` commutate.
- R4: `gate_hi_o` and `gate_lo_o` are never high in the same cycle, including across a change of reference sign.
- R5: Within each commutating pair (hi/mp and mn/lo), both gates are never high together. Between one gate of a pair going low and the other going high there are at least `dead_cycles_i` clock cycles with both low. At a plain commutation there are exactly that many.
- R6: The carrier counts 0,1,…,H,H−1,…,1 and repeats, a period of 2H cycles. H is `half_period_i`, taken at each valley (count 0), with 0 treated as 1. The outer level is requested while the sampled magnitude is greater than the carrier count. A steady magnitude M ≤ H therefore gives an outer request of 2M−1 cycles per period and an outer gate pulse of 2M−1−`dead_cycles_i` cycles.
- R7: A request lasting no more than `dead_cycles_i` cycles produces no gate pulse at all.
- R8: Reference sign and magnitude are sampled only at the carrier valley. A pulse under way when the reference changes keeps the old sign until the valley cycle ends.
- R9: While reset is asserted all gates are low. They stay low through the first clock edge after release, and no gate can rise before the first valley has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | REF_W | Signed reference sample, magnitude in carrier counts |
| half_period_i | input | CNT_W | Carrier half-period in clock cycles |
| dead_cycles_i | input | DT_W | Blanking interval in clock cycles |
| gate_hi_o | output | 1 | Outer high switch enable (+VDC/2) |
| gate_mp_o | output | 1 | Plus-side middle switch enable |
| gate_mn_o | output | 1 | Minus-side middle switch enable |
| gate_lo_o | output | 1 | Outer low switch enable (−VDC/2) |

## Verification
The bench builds the block with its default widths: a 16-bit reference, a 16-bit carrier count and an 8-bit dead count. These cover half-periods of both 312 and 3125 cycles, dead counts of 10 and 40, and the extreme reference −32768, whose magnitude only fits as an unsigned value. Directed scenarios check the exact pulse widths, the carrier periods and the blanking gaps for both half waves. They also cover a pulse that is swallowed by the dead time, a reference change in the middle of a pulse, and the all-low state around reset.

// File: rtl/tlgs_pkg.sv
package tlgs_pkg;
   typedef enum logic {
      HALF_POS = 1'b0,
      HALF_NEG = 1'b1
   } half_e;

   localparam int NUM_GATES = 4;
   localparam int GI_HI = 0;
   localparam int GI_MP = 1;
   localparam int GI_MN = 2;
   localparam int GI_LO = 3;
endpackage

// File: rtl/tlgs_carrier.sv
module tlgs_carrier #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] half_period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             valley_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] h_q;
   logic             up_q;

   assign cnt_o    = cnt_q;
   assign valley_o = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         h_q   <= CNT_W'(1);
         up_q  <= 1'b0;
      end else begin
         if (valley_o) begin
            h_q <= (half_period_i == '0) ? CNT_W'(1) : half_period_i;
         end
         if (up_q) begin
            if (cnt_q >= h_q) begin
               up_q  <= 1'b0;
               cnt_q <= cnt_q - CNT_W'(1);
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end else begin
            if (cnt_q == '0) begin
               up_q  <= 1'b1;
               cnt_q <= CNT_W'(1);
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/tlgs_sampler.sv
module tlgs_sampler
   import tlgs_pkg::*;
#(
   parameter int REF_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valley_i,
   input  logic signed [REF_W-1:0] ref_i,
   output half_e                   half_o,
   output logic [REF_W-1:0]        mag_o,
   output logic                    armed_o
);
   logic [REF_W-1:0] abs_d;

   always_comb begin
      if (ref_i[REF_W-1]) abs_d = ~ref_i + REF_W'(1);
      else                abs_d = ref_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_o  <= HALF_POS;
         mag_o   <= '0;
         armed_o <= 1'b0;
      end else if (valley_i) begin
         half_o  <= ref_i[REF_W-1] ? HALF_NEG : HALF_POS;
         mag_o   <= abs_d;
         armed_o <= 1'b1;
      end
   end
endmodule

// File: rtl/tlgs_ondelay.sv
module tlgs_ondelay #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [DT_W-1:0] dead_i,
   output logic            gate_o
);
   logic [DT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         gate_o <= 1'b0;
      end else if (!req_i) begin
         cnt_q  <= '0;
         gate_o <= 1'b0;
      end else if (cnt_q >= dead_i) begin
         gate_o <= 1'b1;
      end else begin
         cnt_q <= cnt_q + DT_W'(1);
      end
   end
endmodule

// File: rtl/tlgs_gate_seq.sv
module tlgs_gate_seq
   import tlgs_pkg::*;
#(
   parameter int REF_W = 16,
   parameter int CNT_W = 16,
   parameter int DT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [CNT_W-1:0]        half_period_i,
   input  logic [DT_W-1:0]         dead_cycles_i,
   output logic                    gate_hi_o,
   output logic                    gate_mp_o,
   output logic                    gate_mn_o,
   output logic                    gate_lo_o
);
   localparam int CMP_W = (REF_W > CNT_W) ? REF_W : CNT_W;

   if (REF_W < 2) begin : g_bad_ref
      $error("REF_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (DT_W < 1) begin : g_bad_dt
      $error("DT_W must be at least 1");
   end

   logic [CNT_W-1:0]     cnt;
   logic                 valley;
   half_e                half;
   logic [REF_W-1:0]     mag;
   logic                 armed;
   logic                 active;
   logic [NUM_GATES-1:0] req;
   logic [NUM_GATES-1:0] gate;

   tlgs_carrier #(.CNT_W(CNT_W)) u_carrier (
      .clk           (clk),
      .rst_n         (rst_n),
      .half_period_i (half_period_i),
      .cnt_o         (cnt),
      .valley_o      (valley)
   );

   tlgs_sampler #(.REF_W(REF_W)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .valley_i (valley),
      .ref_i    (ref_i),
      .half_o   (half),
      .mag_o    (mag),
      .armed_o  (armed)
   );

   // outer level wanted while the magnitude stays above the carrier
   assign active = armed && (CMP_W'(mag) > CMP_W'(cnt));

   always_comb begin
      req        = '0;
      req[GI_HI] = armed && (half == HALF_POS) && active;
      req[GI_LO] = armed && (half == HALF_NEG) && active;
      req[GI_MP] = armed && ((half == HALF_NEG) || !active);
      req[GI_MN] = armed && ((half == HALF_POS) || !active);
   end

   for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_cell
      tlgs_ondelay #(.DT_W(DT_W)) u_dly (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_i  (req[gi]),
         .dead_i (dead_cycles_i),
         .gate_o (gate[gi])
      );
   end

   assign gate_hi_o = gate[GI_HI];
   assign gate_mp_o = gate[GI_MP];
   assign gate_mn_o = gate[GI_MN];
   assign gate_lo_o = gate[GI_LO];
endmodule

// File: rtl/tlgs_chk.sv
module tlgs_chk #(
   parameter int DT_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            g_hi,
   input logic            g_mp,
   input logic            g_mn,
   input logic            g_lo,
   input logic [DT_W-1:0] dead_i
);
   localparam logic [DT_W:0] GAP_MAX = '1;

   logic [DT_W:0] gap_p;
   logic [DT_W:0] gap_n;
   logic [1:0]    since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_p     <= '0;
         gap_n     <= '0;
         since_rst <= '0;
      end else begin
         if (g_hi || g_mp)        gap_p <= '0;
         else if (gap_p != GAP_MAX) gap_p <= gap_p + 1'b1;
         if (g_mn || g_lo)        gap_n <= '0;
         else if (gap_n != GAP_MAX) gap_n <= gap_n + 1'b1;
         if (since_rst != 2'd3)   since_rst <= since_rst + 2'd1;
      end
   end

   a_r4_outer_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_hi && g_lo));
   a_r5_pos_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_hi && g_mp));
   a_r5_neg_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_mn && g_lo));
   a_r5_pos_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(g_hi) || $rose(g_mp)) |-> (gap_p >= {1'b0, dead_i}));
   a_r5_neg_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(g_mn) || $rose(g_lo)) |-> (gap_n >= {1'b0, dead_i}));
   a_r2_hi_with_mn: assert property (@(posedge clk) disable iff (!rst_n)
      g_hi |-> g_mn);
   a_r3_lo_with_mp: assert property (@(posedge clk) disable iff (!rst_n)
      g_lo |-> g_mp);
   a_r9_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 2'd2) |-> !(g_hi || g_mp || g_mn || g_lo));
endmodule

bind tlgs_gate_seq tlgs_chk #(.DT_W(DT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .g_hi   (gate_hi_o),
   .g_mp   (gate_mp_o),
   .g_mn   (gate_mn_o),
   .g_lo   (gate_lo_o),
   .dead_i (dead_cycles_i)
);

// File: tb/tlgs_gate_seq_tb.sv
module tlgs_gate_seq_tb;
   localparam int REF_W = 16;
   localparam int CNT_W = 16;
   localparam int DT_W  = 8;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic signed [REF_W-1:0] ref_v = '0;
   logic [CNT_W-1:0]        hp = 16'd50;
   logic [DT_W-1:0]         dt = 8'd10;
   logic                    g_hi, g_mp, g_mn, g_lo;
   logic [3:0]              gv;

   int n_vec = 0;
   int n_miss = 0;
   int cyc = 0;
   int run[4], lastw[4], hi_cnt[4], lo_cnt[4], rise_t[4], per[4];
   logic prev[4];
   int bp = 0, bn = 0, min_bp = 0, min_bn = 0, viol = 0;

   always #10 clk = ~clk;

   tlgs_gate_seq #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_i         (ref_v),
      .half_period_i (hp),
      .dead_cycles_i (dt),
      .gate_hi_o     (g_hi),
      .gate_mp_o     (g_mp),
      .gate_mn_o     (g_mn),
      .gate_lo_o     (g_lo)
   );

   assign gv = {g_lo, g_mn, g_mp, g_hi};

   initial begin
      for (int i = 0; i < 4; i++) begin
         run[i] = 0; lastw[i] = -1; hi_cnt[i] = 0; lo_cnt[i] = 0;
         rise_t[i] = 0; per[i] = -1; prev[i] = 1'b0;
      end
   end

   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < 4; i++) begin
         if (gv[i]) begin
            hi_cnt[i]++;
            run[i]++;
            if (!prev[i]) begin
               per[i] = cyc - rise_t[i];
               rise_t[i] = cyc;
            end
         end else begin
            lo_cnt[i]++;
            if (prev[i]) lastw[i] = run[i];
            run[i] = 0;
         end
         prev[i] = gv[i];
      end
      if (!gv[0] && !gv[1]) bp++;
      else begin
         if (bp > 0 && bp < min_bp) min_bp = bp;
         bp = 0;
      end
      if (!gv[2] && !gv[3]) bn++;
      else begin
         if (bn > 0 && bn < min_bn) min_bn = bn;
         bn = 0;
      end
      if ((gv[0] && gv[3]) || (gv[0] && gv[1]) || (gv[2] && gv[3])) viol++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_miss++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      for (int i = 0; i < 4; i++) begin
         hi_cnt[i] = 0; lo_cnt[i] = 0; lastw[i] = -1; per[i] = -1;
      end
      bp = 1000; bn = 1000; min_bp = 1000000; min_bn = 1000000;
   endtask

   task automatic do_reset(input int h, input int d, input int r);
      @(negedge clk);
      rst_n = 1'b0;
      hp = CNT_W'(h);
      dt = DT_W'(d);
      ref_v = REF_W'(r);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic settle_and_clear(input int h);
      repeat (8 * h + 20) @(negedge clk);
      clr();
      repeat (6 * h + 10) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; hp = 16'd50; dt = 8'd0; ref_v = 16'sd20;
      repeat (3) @(negedge clk);
      chk("R9 gates low in reset", int'(gv), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 gates low after first edge", int'(gv), 0);
      @(negedge clk);
      chk("R9 R1 hi and mn after second edge with zero dead", int'(gv), 5);
   endtask

   task automatic t_pos_steady();
      do_reset(50, 10, 20);
      settle_and_clear(50);
      chk("R6 hi pulse width", lastw[0], 29);
      chk("R1 mp pulse width", lastw[1], 51);
      chk("R6 hi period", per[0], 100);
      chk("R2 mn low cycles", lo_cnt[2], 0);
      chk("R2 lo high cycles", hi_cnt[3], 0);
      chk("R5 positive pair blank", min_bp, 10);
   endtask

   task automatic t_neg_steady();
      do_reset(50, 40, -30);
      settle_and_clear(50);
      chk("R6 lo pulse width", lastw[3], 19);
      chk("R5 mn pulse width", lastw[2], 1);
      chk("R3 mp low cycles", lo_cnt[1], 0);
      chk("R3 hi high cycles", hi_cnt[0], 0);
      chk("R5 negative pair blank", min_bn, 40);
      chk("R6 lo period", per[3], 100);
   endtask

   task automatic t_suppress();
      do_reset(50, 10, 3);
      settle_and_clear(50);
      chk("R7 hi swallowed", hi_cnt[0], 0);
      chk("R7 mp width with gap", lastw[1], 85);
   endtask

   task automatic t_zero();
      do_reset(50, 10, 0);
      settle_and_clear(50);
      chk("R1 zero keeps mp on", lo_cnt[1], 0);
      chk("R1 zero keeps mn on", lo_cnt[2], 0);
      chk("R1 zero hi off", hi_cnt[0], 0);
      chk("R1 zero lo off", hi_cnt[3], 0);
   endtask

   task automatic t_full();
      do_reset(50, 10, 50);
      settle_and_clear(50);
      chk("R7 mp swallowed at full scale", hi_cnt[1], 0);
      chk("R6 hi width at full scale", lastw[0], 89);
      chk("R6 hi period at full scale", per[0], 100);
      do_reset(50, 10, -32768);
      settle_and_clear(50);
      chk("R1 most negative keeps lo on", lo_cnt[3], 0);
      chk("R1 most negative hi off", hi_cnt[0], 0);
   endtask

   task automatic t_sign_change();
      do_reset(50, 10, 20);
      repeat (420) @(negedge clk);
      clr();
      do @(negedge clk); while (!g_hi);
      ref_v = -16'sd20;
      repeat (150) @(negedge clk);
      chk("R8 hi pulse cut at valley", lastw[0], 10);
      clr();
      repeat (300) @(negedge clk);
      chk("R8 R3 hi off after sign change", hi_cnt[0], 0);
      chk("R3 mp held after sign change", lo_cnt[1], 0);
      chk("R3 lo width after sign change", lastw[3], 29);
   endtask

   task automatic t_freq();
      do_reset(312, 40, 100);
      settle_and_clear(312);
      chk("R6 period at half 312", per[0], 624);
      chk("R6 width at half 312", lastw[0], 159);
      do_reset(3125, 10, 1000);
      settle_and_clear(3125);
      chk("R6 period at half 3125", per[0], 6250);
      chk("R6 width at half 3125", lastw[0], 1989);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_miss++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      t_reset();
      t_pos_steady();
      t_neg_steady();
      t_suppress();
      t_zero();
      t_full();
      t_sign_change();
      t_freq();
      chk("R4 R5 exclusion violations", viol, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end
endmodule